// File: doc/BRIEF.md
# Dual-Bank NVRAM Header Validator

This block checks the two copies of a non-volatile settings store. The copies sit back to back in a byte memory, and each copy is 8 KB. A pulse on `start` makes the block read all 16384 bytes through a simple read port, one byte per cycle. The port returns each byte one cycle after the request. For each bank the block checks four things: the signature byte, a folded 8-bit header sum, a modulo-65521 dual-accumulator checksum over the bank body, and the 32-bit generation count.

A bank that fails any test reports generation zero. When both banks are done, the block marks as active the bank that holds the higher generation, and it raises `done` for one cycle. Boot logic uses the result to decide which copy to load.

Top module: `nvv_bank_select`

## Requirements
- R1: While reset is applied and after it is released, and before any scan has run, `done`, `rd_en`, `bank_valid`, `gen0`, `gen1` and `active_bank` are all zero.
- R2: A `start` pulse while idle raises `rd_en` for exactly 16384 consecutive cycles. During those cycles `rd_addr` steps from 0 to 0x3FFF by one each cycle. Bank n occupies addresses n*0x2000 to n*0x2000+0x1FFF. A `start` that arrives during a scan is ignored: it neither restarts nor extends the scan.
- R3: A bank is valid only if the byte at bank offset 0 equals 0x5A.
- R4: The header sum is checked as follows. Byte 0 and bytes 2 through 15 are added into a 16-bit sum. The sum is then folded repeatedly, low 8 bits plus the higher bits, until it fits in 8 bits. A bank is valid only if the result equals byte 1.
- R5: The body checksum is checked as follows. Start with low=1 and high=0. For every byte from offset 0x14 to 0x1FFF in order, set low=(low+byte) mod 65521 and then high=(high+low) mod 65521. A bank is valid only if {high,low} equals the big-endian 32-bit word at offsets 16 to 19.
- R6: The generation count of a valid bank is the big-endian 32-bit word at offsets 20 to 23. An invalid bank reports 0 as its generation (`gen0`/`gen1`) and 0 in its `bank_valid` bit (bit n for bank n).
- R7: `active_bank` is 1 when gen0 < gen1 as unsigned numbers. Otherwise it is 0, and this includes the case where the two are equal.
- R8: `done` is high for exactly one cycle, 16385 clock edges after the edge that accepted `start`. That is one cycle after the last byte of bank 1 has been consumed. All results are valid at that moment and hold until the next scan updates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a scan of both banks (ignored while scanning) |
| rd_en | output | 1 | Read request to the byte memory |
| rd_addr | output | 14 | Byte address of the read request |
| rd_data | input | 8 | Read data, valid the cycle after the request |
| bank_valid | output | 2 | Per-bank pass flag, bit n for bank n |
| gen0 | output | 32 | Generation of bank 0, zero if invalid |
| gen1 | output | 32 | Generation of bank 1, zero if invalid |
| active_bank | output | 1 | Index of the bank selected as current |
| done | output | 1 | One-cycle strobe when the scan finishes |

## Verification
The assertions assume that the memory answers every request exactly one cycle later. Under that assumption, the byte offsets seen by the per-bank checker rise by one on every consumed byte, and the assertions on that ordering and on the accumulator ranges rely on it. The bench's memory model registers `rd_data` on the clock edge that samples `rd_en`, so the latency is always one cycle. The bench pokes `start` only while a scan is already running.

// File: rtl/nvv_pkg.sv
package nvv_pkg;
  localparam int BANK_AW    = 13;
  localparam int BANK_BYTES = 1 << BANK_AW;
  localparam int NUM_BANKS  = 2;
  localparam int ADDR_W     = BANK_AW + 1;
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = 32;
  localparam int HDR_LAST   = 15;
  localparam int ADL_OFS    = 16;
  localparam int BODY_OFS   = 20;
  localparam int ADLER_MOD  = 65521;
  localparam logic [7:0] SIG_VAL = 8'h5A;

  // Two folds are enough for any 16-bit value
  function automatic logic [7:0] fold8(input logic [15:0] s);
    logic [15:0] t;
    t = {8'h00, s[7:0]} + {8'h00, s[15:8]};
    t = {8'h00, t[7:0]} + {8'h00, t[15:8]};
    return t[7:0];
  endfunction
endpackage

// File: rtl/nvv_rst_sync.sv
module nvv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/nvv_hdr_sum.sv
module nvv_hdr_sum #(
  parameter int AW = nvv_pkg::BANK_AW,
  parameter int LAST = nvv_pkg::HDR_LAST
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [AW-1:0] ofs,
  input  logic [7:0]    byte_i,
  output logic [15:0]   sum_q
);
  logic        take;
  logic [15:0] base;
  logic [15:0] sum_d;

  always_comb begin
    take  = vld && ((ofs == '0) || ((ofs >= AW'(2)) && (ofs <= AW'(LAST))));
    base  = (ofs == '0) ? 16'h0000 : sum_q;
    sum_d = take ? (base + {8'h00, byte_i}) : sum_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sum_q <= 16'h0000;
    else if (take) sum_q <= sum_d;
  end

  // R4: fifteen bytes can never exceed 15*255
  // R4
  hsum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q <= 16'd3825);
endmodule

// File: rtl/nvv_adler_acc.sv
module nvv_adler_acc #(
  parameter int MOD = nvv_pkg::ADLER_MOD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        init,
  input  logic [7:0]  byte_i,
  output logic [15:0] lo_n,
  output logic [15:0] hi_n
);
  localparam logic [16:0] M17 = 17'(MOD);

  logic [15:0] lo_q, hi_q;
  logic [15:0] base_lo, base_hi;
  logic [16:0] s_lo, s_hi, r_lo, r_hi;

  always_comb begin
    base_lo = init ? 16'h0001 : lo_q;
    base_hi = init ? 16'h0000 : hi_q;
    s_lo    = {1'b0, base_lo} + {9'h000, byte_i};
    r_lo    = (s_lo >= M17) ? (s_lo - M17) : s_lo;
    lo_n    = r_lo[15:0];
    s_hi    = {1'b0, base_hi} + {1'b0, lo_n};
    r_hi    = (s_hi >= M17) ? (s_hi - M17) : s_hi;
    hi_n    = r_hi[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= 16'h0001;
      hi_q <= 16'h0000;
    end else if (en) begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  // R5
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(lo_q) < MOD) && (32'(hi_q) < MOD));
endmodule

// File: rtl/nvv_bank_check.sv
module nvv_bank_check
  import nvv_pkg::*;
#(
  parameter int AW = BANK_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [AW-1:0] ofs,
  input  logic [7:0]    byte_i,
  output logic          res_stb,
  output logic          res_ok,
  output logic [31:0]   res_gen
);
  logic [7:0]  sig_q, cks_q;
  logic [31:0] adl_q, gen_q;
  logic [15:0] hsum;
  logic [15:0] lo_n, hi_n;
  logic        body_en, body_init;
  logic        cap_sig, cap_cks, cap_adl, cap_gen;

  always_comb begin
    cap_sig   = vld && (ofs == '0);
    cap_cks   = vld && (ofs == AW'(1));
    cap_adl   = vld && (ofs >= AW'(ADL_OFS)) && (ofs < AW'(BODY_OFS));
    cap_gen   = vld && (ofs >= AW'(BODY_OFS)) && (ofs < AW'(BODY_OFS + 4));
    body_en   = vld && (ofs >= AW'(BODY_OFS));
    body_init = (ofs == AW'(BODY_OFS));
  end

  nvv_hdr_sum #(.AW(AW), .LAST(HDR_LAST)) i_hsum (
    .clk(clk), .rst_n(rst_n), .vld(vld), .ofs(ofs), .byte_i(byte_i), .sum_q(hsum)
  );

  nvv_adler_acc #(.MOD(ADLER_MOD)) i_adler (
    .clk(clk), .rst_n(rst_n), .en(body_en), .init(body_init), .byte_i(byte_i),
    .lo_n(lo_n), .hi_n(hi_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= 8'h00;
      cks_q <= 8'h00;
    end else begin
      if (cap_sig) sig_q <= byte_i;
      if (cap_cks) cks_q <= byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adl_q <= 32'h0;
      gen_q <= 32'h0;
    end else begin
      if (cap_adl) adl_q <= {adl_q[23:0], byte_i};
      if (cap_gen) gen_q <= {gen_q[23:0], byte_i};
    end
  end

  always_comb begin
    res_stb = vld && (ofs == '1);
    res_ok  = (sig_q == SIG_VAL) && (cks_q == fold8(hsum)) && (adl_q == {hi_n, lo_n});
    res_gen = res_ok ? gen_q : 32'h0;
  end

  // R2: input contract, offsets rise by one per consumed byte
  // R2
  ofs_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && (ofs != '0)) |-> ($past(vld) && (ofs == $past(ofs) + AW'(1))));
endmodule

// File: rtl/nvv_bank_select.sv
module nvv_bank_select
  import nvv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic [1:0]        bank_valid,
  output logic [31:0]       gen0,
  output logic [31:0]       gen1,
  output logic              active_bank,
  output logic              done
);
  logic              rst_n_s;
  logic              run_q, run_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              dvld_q;
  logic [ADDR_W-1:0] doff_q;
  logic              done_q, done_d;
  logic              act_q, act_d;
  logic              res_stb, res_ok;
  logic [31:0]       res_gen;
  logic              last_bank;

  nvv_rst_sync i_rsync (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  // Address sequencer: next state
  always_comb begin
    run_d  = run_q;
    addr_d = addr_q;
    if (!run_q && start) begin
      run_d  = 1'b1;
      addr_d = '0;
    end else if (run_q) begin
      addr_d = addr_q + ADDR_W'(1);
      if (addr_q == '1) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      run_q  <= 1'b0;
      addr_q <= '0;
      dvld_q <= 1'b0;
      doff_q <= '0;
    end else begin
      run_q  <= run_d;
      addr_q <= addr_d;
      dvld_q <= run_q;
      if (run_q) doff_q <= addr_q;
    end
  end

  assign rd_en   = run_q;
  assign rd_addr = addr_q;

  nvv_bank_check #(.AW(BANK_AW)) i_check (
    .clk(clk), .rst_n(rst_n_s), .vld(dvld_q), .ofs(doff_q[BANK_AW-1:0]),
    .byte_i(rd_data), .res_stb(res_stb), .res_ok(res_ok), .res_gen(res_gen)
  );

  assign last_bank = doff_q[BANK_AW];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic        hit;
    logic        val_r;
    logic [31:0] gen_r;
    assign hit = res_stb && (last_bank == 1'(b));
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) begin
        val_r <= 1'b0;
        gen_r <= 32'h0;
      end else if (hit) begin
        val_r <= res_ok;
        gen_r <= res_gen;
      end
    end
  end

  // Selection and completion: next state
  always_comb begin
    done_d = res_stb && last_bank;
    act_d  = act_q;
    if (done_d) act_d = (g_bank[0].gen_r < res_gen);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      done_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      act_q  <= act_d;
    end
  end

  assign bank_valid  = {g_bank[1].val_r, g_bank[0].val_r};
  assign gen0        = g_bank[0].gen_r;
  assign gen1        = g_bank[1].gen_r;
  assign active_bank = act_q;
  assign done        = done_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);
  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(1)));
  // R2
  addr_first_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rd_en) |-> (rd_addr == '0));
  // R7
  select_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> (active_bank == (gen0 < gen1)));
  // R6
  gen_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> ((bank_valid[0] || gen0 == 32'h0) && (bank_valid[1] || gen1 == 32'h0)));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !rd_en);
endmodule

// File: tb/test_nvv_bank_select.sv
module test_nvv_bank_select;
  localparam int BANK = 8192;
  localparam int TOTAL = 2 * BANK;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        rd_en;
  logic [13:0] rd_addr;
  logic [7:0]  rd_data;
  logic [1:0]  bank_valid;
  logic [31:0] gen0, gen1;
  logic        active_bank;
  logic        done;

  int tests = 0;
  int fails = 0;
  int nreads = 0;
  int addr_err = 0;
  int exp_addr = 0;
  logic [7:0] mem [TOTAL];

  always #5 clk = ~clk;

  nvv_bank_select i_nvv_bank_select (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .bank_valid(bank_valid), .gen0(gen0), .gen1(gen1),
    .active_bank(active_bank), .done(done)
  );

  // Memory with one cycle read latency
  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
      if (int'(rd_addr) != exp_addr) addr_err <= addr_err + 1;
      exp_addr <= exp_addr + 1;
      nreads <= nreads + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build_bank(input int b, input logic [31:0] gen, input int seed,
                            input bit bad_sig, input bit bad_cks, input bit bad_adl,
                            input bit all_ff);
    int base;
    int s;
    longint lo, hi;
    base = b * BANK;
    for (int i = 24; i < BANK; i++)
      mem[base+i] = all_ff ? 8'hFF : 8'((i * seed) + (i >> 3) + seed);
    mem[base+0] = bad_sig ? 8'h5B : 8'h5A;
    mem[base+2] = 8'h01;
    mem[base+3] = 8'hFF;
    for (int i = 4; i < 16; i++) mem[base+i] = 8'(8'h41 + i + seed);
    mem[base+20] = gen[31:24];
    mem[base+21] = gen[23:16];
    mem[base+22] = gen[15:8];
    mem[base+23] = gen[7:0];
    s = int'(mem[base+0]);
    for (int i = 2; i < 16; i++) s += int'(mem[base+i]);
    while (s > 255) s = (s & 255) + (s >> 8);
    mem[base+1] = 8'(s) ^ (bad_cks ? 8'h01 : 8'h00);
    lo = 1;
    hi = 0;
    for (int i = 20; i < BANK; i++) begin
      lo = (lo + longint'(mem[base+i])) % 65521;
      hi = (hi + lo) % 65521;
    end
    mem[base+16] = 8'(hi >> 8);
    mem[base+17] = 8'(hi);
    mem[base+18] = 8'(lo >> 8);
    mem[base+19] = 8'(lo);
    if (bad_adl) mem[base+BANK-1] = mem[base+BANK-1] ^ 8'h01;
  endtask

  task automatic scan(input string req, input bit poke,
                      input logic [1:0] ev, input logic [31:0] eg0,
                      input logic [31:0] eg1, input logic eact);
    int lat;
    nreads = 0;
    exp_addr = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (poke && lat == 100) start = 1'b1;
      if (poke && lat == 101) start = 1'b0;
    end while (!done && lat < 40000);
    chk({req, " R8 latency"}, 32'(lat), 32'(TOTAL + 1));
    chk({req, " R2 read count"}, 32'(nreads), 32'(TOTAL));
    chk({req, " R2 address order"}, 32'(addr_err), 32'h0);
    chk({req, " R6 valid flags"}, {30'h0, bank_valid}, {30'h0, ev});
    chk({req, " R6 gen0"}, gen0, eg0);
    chk({req, " R6 gen1"}, gen1, eg1);
    chk({req, " R7 active"}, {31'h0, active_bank}, {31'h0, eact});
    @(negedge clk);
    chk({req, " R8 single pulse"}, {31'h0, done}, 32'h0);
    chk({req, " R8 results hold"}, gen0 ^ gen1, eg0 ^ eg1);
  endtask

  task automatic t_reset;
    chk("R1 done", {31'h0, done}, 32'h0);
    chk("R1 rd_en", {31'h0, rd_en}, 32'h0);
    chk("R1 valid", {30'h0, bank_valid}, 32'h0);
    chk("R1 gen0", gen0, 32'h0);
    chk("R1 gen1", gen1, 32'h0);
    chk("R1 active", {31'h0, active_bank}, 32'h0);
  endtask

  task automatic t_newer1;   // R7, R5
    build_bank(0, 32'd5, 3, 0, 0, 0, 0);
    build_bank(1, 32'd9, 7, 0, 0, 0, 0);
    scan("newer bank1", 0, 2'b11, 32'd5, 32'd9, 1'b1);
  endtask

  task automatic t_newer0;   // R7
    build_bank(0, 32'd9, 11, 0, 0, 0, 0);
    build_bank(1, 32'd5, 13, 0, 0, 0, 0);
    scan("newer bank0", 0, 2'b11, 32'd9, 32'd5, 1'b0);
  endtask

  task automatic t_tie;      // R7 ties pick bank 0
    build_bank(0, 32'd4, 17, 0, 0, 0, 0);
    build_bank(1, 32'd4, 19, 0, 0, 0, 0);
    scan("tie R7", 0, 2'b11, 32'd4, 32'd4, 1'b0);
  endtask

  task automatic t_badsig;   // R3
    build_bank(0, 32'd50, 23, 1, 0, 0, 0);
    build_bank(1, 32'd3, 29, 0, 0, 0, 0);
    scan("bad signature R3", 0, 2'b10, 32'd0, 32'd3, 1'b1);
  endtask

  task automatic t_badcks;   // R4, and R2 start ignored mid-scan
    build_bank(0, 32'd7, 31, 0, 0, 0, 0);
    build_bank(1, 32'd70, 37, 0, 1, 0, 0);
    scan("bad header sum R4 with start poke R2", 1, 2'b01, 32'd7, 32'd0, 1'b0);
  endtask

  task automatic t_badadl;   // R5
    build_bank(0, 32'd100, 41, 0, 0, 1, 0);
    build_bank(1, 32'd2, 43, 0, 0, 0, 0);
    scan("bad body checksum R5", 0, 2'b10, 32'd0, 32'd2, 1'b1);
  endtask

  task automatic t_allff;    // R5 modulo wrap, R7 unsigned compare
    build_bank(0, 32'h8000_0001, 1, 0, 0, 0, 1);
    build_bank(1, 32'h7FFF_FFFF, 1, 0, 0, 0, 1);
    scan("all ones body R5", 0, 2'b11, 32'h8000_0001, 32'h7FFF_FFFF, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    for (int i = 0; i < TOTAL; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_newer1();
    t_newer0();
    t_tie();
    t_badsig();
    t_badcks();
    t_badadl();
    t_allff();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule